// File: doc/BRIEF.md
# Three-Wire Lane Symbol Mapper and Transition Encoder

This block is the transmit-side digital logic for one lane of a trio-signaling link, in which three wires carry three distinct levels in every unit interval. It takes 16-bit data words through a valid/ready handshake. It expands each word into a group of seven quinary symbols. It then turns each symbol into a move from the present line state to a different one. The outputs are symbolic level codes for wires A, B and C. Analog drivers downstream turn these codes into voltages.

Each clock cycle is one unit interval. While a group is being sent, the line state changes on every cycle. When no word is pending, the lane keeps its last state. A new word can be accepted in the cycle that carries the last symbol of the current group. Words sent back to back therefore stream out with no idle interval between groups.

Top module: `trio_lane_tx`

## Requirements
- R1: While rst_n is low (asynchronous, active low), the line state is +x and in_ready is 1. +x means wire A HIGH, wire B LOW and wire C MID.
- R2: The level codes are LOW=2'd0, MID=2'd1 and HIGH=2'd2. In every cycle the three wires carry three different codes, and code 2'd3 never appears.
- R3: An accepted word is read as an unsigned integer and sent as its seven base-5 digits, most significant digit first. Digit k of the group is applied at the (k+1)-th rising edge after the accepting edge.
- R4: Digit value 4 encodes as {flip,rotate,polarity}=3'b100. Digit values 0 to 3 encode with flip=0, rotate=digit bit 1 and polarity=digit bit 0.
- R5: A symbol with flip=1 keeps the phase (x, y or z) and inverts the sign.
- R6: A symbol with flip=0 moves the phase forward x->y->z->x when rotate=1 and backward when rotate=0. It inverts the sign when polarity=1 and keeps the sign when polarity=0.
- R7: For phase p at wire index p (A=0, B=1, C=2), that wire is HIGH, wire (p+1) mod 3 is LOW and wire (p+2) mod 3 is MID. For a negative sign, HIGH and LOW are swapped.
- R8: in_ready is 0 during the first six symbols of a group. It is 1 on the seventh symbol and when the block is idle. A word offered on the seventh symbol starts its group in the very next unit interval.
- R9: When no symbol is being sent, the wire levels stay constant. While in_ready is 0, changes on in_word and in_valid have no effect on the group in flight.
- R10: While a symbol is being sent, the line state at the next edge differs from the current one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Unit-interval clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A data word is offered |
| in_word | input | 16 | Data word to transmit |
| in_ready | output | 1 | The block takes a word at this edge if in_valid is high |
| wire_a | output | 2 | Level code for wire A |
| wire_b | output | 2 | Level code for wire B |
| wire_c | output | 2 | Level code for wire C |

## Verification
The hardest case to reach from the ports is the handover on the seventh symbol. There, a new word must be taken while the old group's last digit is still being applied, and the next group must begin with no idle interval and no repeated state. The bench holds in_valid high through a whole group and changes in_word while in_ready is low. It then checks every unit interval across the boundary against an independent digit-and-state model. Words chosen to contain the digit 4 (for example 0xFFFF gives 4,0,4,4,1,2,0) exercise flips next to rotations. A reset asserted in the middle of a group checks that the lane returns to +x.

// File: rtl/trio_pkg.sv
package trio_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MID  = 2'd1,
    LVL_HIGH = 2'd2
  } lvl_e;

  // phase: 0 = x, 1 = y, 2 = z ; neg: sign of the state
  typedef struct packed {
    logic       neg;
    logic [1:0] phase;
  } line_st_t;

  typedef struct packed {
    logic flip;
    logic rot;
    logic pol;
  } sym_code_t;

  localparam line_st_t ST_POS_X = '{neg: 1'b0, phase: 2'd0};

  function automatic sym_code_t sym_encode(input logic [2:0] digit);
    sym_code_t c;
    if (digit == 3'd4) c = '{flip: 1'b1, rot: 1'b0, pol: 1'b0};
    else               c = '{flip: 1'b0, rot: digit[1], pol: digit[0]};
    return c;
  endfunction

  function automatic logic [1:0] phase_step(input logic [1:0] p, input logic fwd);
    logic [1:0] r;
    if (fwd) r = (p == 2'd2) ? 2'd0 : p + 2'd1;
    else     r = (p == 2'd0) ? 2'd2 : p - 2'd1;
    return r;
  endfunction

  function automatic line_st_t apply_sym(input line_st_t s, input sym_code_t c);
    line_st_t n;
    if (c.flip) begin
      n.phase = s.phase;
      n.neg   = ~s.neg;
    end else begin
      n.phase = phase_step(s.phase, c.rot);
      n.neg   = s.neg ^ c.pol;
    end
    return n;
  endfunction

  // level of wire w (0=A,1=B,2=C) in state s
  function automatic lvl_e wire_level(input line_st_t s, input int w);
    lvl_e l;
    if (w == int'(s.phase))                          l = s.neg ? LVL_LOW : LVL_HIGH;
    else if (w == int'(phase_step(s.phase, 1'b1)))   l = s.neg ? LVL_HIGH : LVL_LOW;
    else                                             l = LVL_MID;
    return l;
  endfunction

endpackage

// File: rtl/trio_digit_mapper.sv
module trio_digit_mapper #(
  parameter int WORD_W = 16,
  parameter int SYMS   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  output logic              sym_valid,
  output logic [2:0]        sym_digit
);
  localparam int IDX_W = $clog2(SYMS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SYMS - 1);

  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word_q;
  logic              last_sym;
  logic              accept;

  // base-5 digit number idx, counted from the most significant end
  function automatic logic [2:0] digit_at(input logic [WORD_W-1:0] w,
                                          input logic [IDX_W-1:0] k);
    logic [WORD_W-1:0] v;
    v = w;
    for (int j = 0; j < SYMS; j++)
      if (j < (SYMS - 1 - int'(k))) v = v / WORD_W'(5);
    return 3'(v % WORD_W'(5));
  endfunction

  assign last_sym  = busy && (idx == LAST_IDX);
  assign in_ready  = !busy || last_sym;
  assign accept    = in_valid && in_ready;
  assign sym_valid = busy;
  assign sym_digit = digit_at(word_q, idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      word_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      idx    <= '0;
      word_q <= in_word;
    end else if (busy) begin
      if (last_sym) busy <= 1'b0;
      else          idx  <= idx + 1'b1;
    end
  end

  // R8: ready stays low inside a group until its last symbol
  p_ready_low_in_group_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx != LAST_IDX) |-> !in_ready);

  // R9: a word held in flight is not replaced before the group ends
  p_word_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_sym) |=> $stable(word_q));

  // R3: symbol index never leaves the group
  p_idx_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST_IDX);

endmodule

// File: rtl/trio_state_encoder.sv
module trio_state_encoder
  import trio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  input  logic [2:0] sym_digit,
  output logic [1:0] lvl_out [3]
);
  line_st_t  state;
  sym_code_t code;

  assign code = sym_encode(sym_digit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state <= ST_POS_X;
    else if (sym_valid) state <= apply_sym(state, code);
  end

  for (genvar w = 0; w < 3; w++) begin : g_wire
    assign lvl_out[w] = wire_level(state, w);
  end

  // R10: every symbol moves the line to a different state
  p_state_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> (state != $past(state)));

  // R9: with no symbol the line holds
  p_state_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> $stable(state));

  // R2: three distinct legal levels on the wires
  p_levels_distinct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_out[0] != lvl_out[1]) && (lvl_out[1] != lvl_out[2]) &&
    (lvl_out[0] != lvl_out[2]) && (lvl_out[0] != 2'd3) &&
    (lvl_out[1] != 2'd3) && (lvl_out[2] != 2'd3));

  // R5: a flip keeps the phase
  p_flip_keeps_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && code.flip) |=> (state.phase == $past(state.phase)));

  // R6: a non-flip symbol changes the phase
  p_rotate_moves_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !code.flip) |=> (state.phase != $past(state.phase)));

  // R1 is covered at the ports by the bench; state sanity here
  p_phase_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state.phase != 2'd3);

endmodule

// File: rtl/trio_lane_tx.sv
module trio_lane_tx #(
  parameter int WORD_W = 16,
  parameter int SYMS   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  output logic [1:0]        wire_a,
  output logic [1:0]        wire_b,
  output logic [1:0]        wire_c
);
  logic       sym_valid;
  logic [2:0] sym_digit;
  logic [1:0] lvl [3];

  trio_digit_mapper #(.WORD_W(WORD_W), .SYMS(SYMS)) u_mapper (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .in_ready  (in_ready),
    .sym_valid (sym_valid),
    .sym_digit (sym_digit)
  );

  trio_state_encoder u_encoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .sym_digit (sym_digit),
    .lvl_out   (lvl)
  );

  assign wire_a = lvl[0];
  assign wire_b = lvl[1];
  assign wire_c = lvl[2];

  // R8: ready never falls while idle without an accepted word
  p_ready_after_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);

endmodule

// File: tb/trio_lane_tx_test.sv
module trio_lane_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic        in_ready;
  logic [1:0]  wire_a, wire_b, wire_c;

  int checks = 0;
  int errors = 0;

  // bench model of the line: phase index and sign
  int m_ph  = 0;
  int m_neg = 0;

  always #2.5 clk = ~clk;

  trio_lane_tx uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .wire_a(wire_a), .wire_b(wire_b), .wire_c(wire_c)
  );

  function automatic int digit_of(input int w, input int k);
    int d [7];
    int t = w;
    for (int i = 6; i >= 0; i--) begin
      d[i] = t % 5;
      t = t / 5;
    end
    return d[k];
  endfunction

  task automatic model_step(input int d);
    if (d == 4) m_neg = 1 - m_neg;
    else begin
      m_ph  = (d >= 2) ? (m_ph + 1) % 3 : (m_ph + 2) % 3;
      m_neg = m_neg ^ (d & 1);
    end
  endtask

  function automatic logic [5:0] model_lvls();
    logic [1:0] l [3];
    l[m_ph]           = m_neg ? 2'd0 : 2'd2;
    l[(m_ph + 1) % 3] = m_neg ? 2'd2 : 2'd0;
    l[(m_ph + 2) % 3] = 2'd1;
    return {l[0], l[1], l[2]};
  endfunction

  task automatic check_lines(input string req);
    logic [5:0] exp_v = model_lvls();
    checks++;
    if ({wire_a, wire_b, wire_c} !== exp_v) begin
      errors++;
      $display("FAIL %s lines act=%0d/%0d/%0d exp=%0d/%0d/%0d", req,
               wire_a, wire_b, wire_c, exp_v[5:4], exp_v[3:2], exp_v[1:0]);
    end
  endtask

  task automatic check_ready(input string req, input logic e);
    checks++;
    if (in_ready !== e) begin
      errors++;
      $display("FAIL %s in_ready act=%b exp=%b", req, in_ready, e);
    end
  endtask

  // single word, group of seven checked symbol by symbol (R3 R4 R5 R6 R7 R10)
  task automatic send_one(input logic [15:0] w);
    @(negedge clk);
    check_ready("R8 idle", 1'b1);
    in_valid = 1'b1; in_word = w;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_word = ~w;
    check_ready("R8 group start", 1'b0);
    for (int k = 0; k < 7; k++) begin
      @(posedge clk);
      @(negedge clk);
      model_step(digit_of(int'(w), k));
      check_lines("R3 R6 digit apply");
      if (k < 6) check_ready("R8 ready in group", k == 5);
    end
    check_ready("R8 idle after group", 1'b1);
  endtask

  // R9: idle holds lines, ready stays high
  task automatic idle_hold(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check_lines("R9 idle hold");
      check_ready("R9 idle ready", 1'b1);
    end
  endtask

  // R8 R9: back-to-back words, in_word changes while not ready
  task automatic back_to_back(input logic [15:0] w1, input logic [15:0] w2);
    @(negedge clk);
    in_valid = 1'b1; in_word = w1;
    @(posedge clk);
    @(negedge clk);
    in_word = 16'h5A5A;
    for (int k = 0; k < 14; k++) begin
      if (k == 5) in_word = w2;
      @(posedge clk);
      @(negedge clk);
      if (k < 7) model_step(digit_of(int'(w1), k));
      else       model_step(digit_of(int'(w2), k - 7));
      check_lines("R8 back-to-back stream");
      if (k == 6) begin
        in_valid = 1'b0;
        check_ready("R8 second group start", 1'b0);
      end
    end
    check_ready("R8 idle after stream", 1'b1);
  endtask

  // R1: reset in the middle of a group returns to +x
  task automatic mid_reset(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_word = w;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      model_step(digit_of(int'(w), k));
    end
    check_lines("R3 before reset");
    rst_n = 1'b0;
    m_ph = 0; m_neg = 0;
    #1;
    check_lines("R1 reset mid group");
    check_ready("R1 reset ready", 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    idle_hold(2);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    check_lines("R1 reset levels A high B low C mid");
    check_ready("R1 reset ready", 1'b1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle_hold(2);
    send_one(16'h0000);   // all digits 0: backward rotations, R6
    send_one(16'hFFFF);   // digits 4,0,4,4,1,2,0: flips, R4 R5
    send_one(16'h1234);
    idle_hold(3);
    send_one(16'd2344);   // digits 0,0,3,3,3,3,4
    back_to_back(16'hBEEF, 16'h0F0F);
    idle_hold(2);
    mid_reset(16'hC3A5);
    send_one(16'd19531);  // R7: varied states
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule